// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps two independent guessers. The first is a per-branch guesser: a table indexed by fetch-address bits holds each branch's own recent outcomes, and that pattern selects a saturating counter. The second is a path guesser: one shared shift register of recent resolved outcomes selects a second bank of saturating counters. A chooser bank, indexed by the same shared history, learns which of the two guessers has been right more often. The chooser's verdict forms the final answer.

A fetch unit raises a request with a fetch address. The answer appears exactly two clock cycles later. The answer carries the final direction and both component guesses, and the fetch unit keeps the component guesses with the branch. When the branch resolves, the pipeline returns its address, the real outcome and the two component guesses that were recorded. The block then trains all three banks and shifts the outcome into both histories. The shared history advances only on resolution, so nothing here repairs wrong-path history.

Top module: `tourn_bp`

## Requirements
- R1: After a synchronous active-high reset, `pred_valid` is low. A prediction made before any update returns 0 on `pred_taken`, `pred_local`, `pred_global` and `pred_use_global`. A reset in mid-run returns the block to that same state.
- R2: `pred_valid` goes high exactly two cycles after a cycle with `pred_req` high, stays low in the cycle between, and is high only in cycles that follow such a request by two.
- R3: The per-branch history entry is selected by `pc[PC_LSB +: LHT_IDX_W]` (bits 9:2 by default). That LHIST_W-bit history selects an LCTR_W-bit counter, and `pred_local` is the counter's top bit. Histories reset to 0 and counters reset to 2^(LCTR_W-1)-1 (3), so they start weakly not taken.
- R4: The GHIST_W-bit shared history selects a GCTR_W-bit counter, and `pred_global` is its top bit. The counters reset to 1.
- R5: A CH_W-bit chooser counter is selected by the shared history. Its top bit is driven on `pred_use_global`, and when that bit is 1 `pred_taken` follows `pred_global`, otherwise `pred_local`. Chooser counters reset to 1, which favours the per-branch guesser.
- R6: Every counter saturates. It counts up on a taken update and down on a not-taken update, stops at its all-ones value, and never goes below 0.
- R7: A chooser counter changes only when `upd_local_pred` and `upd_global_pred` differ. It then moves up if the global guess matched `upd_taken`, and down otherwise. Updates where the two guesses agree leave the chooser unchanged.
- R8: Each update shifts `upd_taken` into bit 0 of the shared history, and the older bits move up by one place. Without an update the shared history holds its value.
- R9: An update shifts its outcome into bit 0 of the history entry for `upd_pc` only. The histories of other branches are untouched.
- R10: An update trains the per-branch counter selected by the branch's history before the shift, and the global and chooser counters selected by the shared history before the shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pred_req | input | 1 | Prediction request for `pred_pc` |
| pred_pc | input | PC_W | Fetch address to predict |
| pred_valid | output | 1 | Prediction result valid (two cycles after request) |
| pred_taken | output | 1 | Final direction, 1 = taken |
| pred_local | output | 1 | Per-branch guesser direction |
| pred_global | output | 1 | Shared-history guesser direction |
| pred_use_global | output | 1 | Chooser picked the shared-history guesser |
| upd_valid | input | 1 | Resolved branch update strobe |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 = taken |
| upd_local_pred | input | 1 | Per-branch guess recorded at prediction |
| upd_global_pred | input | 1 | Shared-history guess recorded at prediction |

## Verification
The hardest state to reach from the ports is a chooser entry that has swung over to the shared-history guesser. Every update also moves the shared history, so a run of disagreeing updates normally scatters across many chooser entries. The stimulus gets around this by resolving the same branch not-taken several times in a row. That keeps the shared history at zero, so the same chooser entry and global counter are trained each time, driving them up against saturation and down to their floor. The bench then walks a mixed vector list against its own reference tables, and checks that agreeing updates and updates to other branches leave the observed guesses unchanged.

// File: rtl/tourn_bp_pkg.sv
package tourn_bp_pkg;

  // One prediction result as produced by the second pipeline stage.
  typedef struct packed {
    logic taken;
    logic local_dir;
    logic global_dir;
    logic use_global;
  } bp_result_t;

  // Reset value of a saturating counter: weakly below the taken threshold.
  function automatic int weak_nt(input int width);
    return (1 << (width - 1)) - 1;
  endfunction

endpackage

// File: rtl/tp_ctr_table.sv
// Bank of saturating counters: one synchronous read port for prediction,
// one read-modify-write training port.
module tp_ctr_table #(
  parameter int IDX_W     = 8,
  parameter int CTR_W     = 2,
  parameter int RESET_VAL = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_addr,
  output logic [CTR_W-1:0] rd_data,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_addr,
  input  logic             upd_up
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [CTR_W-1:0] CMAX  = {CTR_W{1'b1}};
  localparam logic [CTR_W-1:0] CINIT = CTR_W'(RESET_VAL);

  logic [CTR_W-1:0] mem [DEPTH];
  logic [CTR_W-1:0] cur, nxt;

  always_comb begin
    cur = mem[upd_addr];
    nxt = cur;
    if (upd_up && cur != CMAX)
      nxt = cur + 1'b1;
    else if (!upd_up && cur != '0)
      nxt = cur - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= CINIT;
      rd_data <= CINIT;
    end else begin
      if (rd_en)  rd_data       <= mem[rd_addr];
      if (upd_en) mem[upd_addr] <= nxt;
    end
  end
endmodule

// File: rtl/tp_hist_table.sv
// Per-branch outcome histories: synchronous read for prediction,
// combinational read plus shift for training.
module tp_hist_table #(
  parameter int IDX_W  = 8,
  parameter int HIST_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [HIST_W-1:0] rd_hist,
  input  logic              upd_en,
  input  logic [IDX_W-1:0]  upd_idx,
  input  logic              upd_taken,
  output logic [HIST_W-1:0] upd_hist
);
  localparam int DEPTH = 1 << IDX_W;

  logic [HIST_W-1:0] mem [DEPTH];

  assign upd_hist = mem[upd_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rd_hist <= '0;
    end else begin
      if (rd_en)  rd_hist      <= mem[rd_idx];
      if (upd_en) mem[upd_idx] <= {upd_hist[HIST_W-2:0], upd_taken};
    end
  end
endmodule

// File: rtl/tp_path_hist.sv
// Shared history of resolved outcomes, newest in bit 0.
module tp_path_hist #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         upd_en,
  input  logic         upd_taken,
  output logic [W-1:0] hist
);
  always_ff @(posedge clk) begin
    if (rst)         hist <= '0;
    else if (upd_en) hist <= {hist[W-2:0], upd_taken};
  end
endmodule

// File: rtl/tourn_bp.sv
module tourn_bp
  import tourn_bp_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int PC_LSB    = 2,
  parameter int LHT_IDX_W = 8,
  parameter int LHIST_W   = 8,
  parameter int LCTR_W    = 3,
  parameter int GHIST_W   = 8,
  parameter int GCTR_W    = 2,
  parameter int CH_W      = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pred_req,
  input  logic [PC_W-1:0] pred_pc,
  output logic            pred_valid,
  output logic            pred_taken,
  output logic            pred_local,
  output logic            pred_global,
  output logic            pred_use_global,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic            upd_local_pred,
  input  logic            upd_global_pred
);
  localparam int LCTR_INIT = weak_nt(LCTR_W);
  localparam int GCTR_INIT = weak_nt(GCTR_W);
  localparam int CH_INIT   = weak_nt(CH_W);

  // Address bits not used for indexing are left unread on purpose.
  logic unused_pc_bits;
  assign unused_pc_bits = ^{pred_pc, upd_pc};

  logic [LHT_IDX_W-1:0] pred_idx, upd_idx;
  assign pred_idx = pred_pc[PC_LSB +: LHT_IDX_W];
  assign upd_idx  = upd_pc[PC_LSB +: LHT_IDX_W];

  logic [GHIST_W-1:0] ghr_q;
  logic [LHIST_W-1:0] lhist_s1, lhist_upd;
  logic [GCTR_W-1:0]  gctr_s1;
  logic [CH_W-1:0]    ch_s1;
  logic [LCTR_W-1:0]  lctr_s2;
  logic [GCTR_W-1:0]  gctr_s2;
  logic [CH_W-1:0]    ch_s2;
  logic               valid_s1, valid_s2;
  logic               ch_train;

  // Chooser trains only when the recorded guesses disagree.
  assign ch_train = upd_valid && (upd_local_pred != upd_global_pred);

  tp_path_hist #(.W(GHIST_W)) u_ghr (
    .clk(clk), .rst(rst),
    .upd_en(upd_valid), .upd_taken(upd_taken),
    .hist(ghr_q)
  );

  tp_hist_table #(.IDX_W(LHT_IDX_W), .HIST_W(LHIST_W)) u_lht (
    .clk(clk), .rst(rst),
    .rd_en(pred_req), .rd_idx(pred_idx), .rd_hist(lhist_s1),
    .upd_en(upd_valid), .upd_idx(upd_idx), .upd_taken(upd_taken),
    .upd_hist(lhist_upd)
  );

  tp_ctr_table #(.IDX_W(LHIST_W), .CTR_W(LCTR_W), .RESET_VAL(LCTR_INIT)) u_lct (
    .clk(clk), .rst(rst),
    .rd_en(valid_s1), .rd_addr(lhist_s1), .rd_data(lctr_s2),
    .upd_en(upd_valid), .upd_addr(lhist_upd), .upd_up(upd_taken)
  );

  tp_ctr_table #(.IDX_W(GHIST_W), .CTR_W(GCTR_W), .RESET_VAL(GCTR_INIT)) u_gct (
    .clk(clk), .rst(rst),
    .rd_en(pred_req), .rd_addr(ghr_q), .rd_data(gctr_s1),
    .upd_en(upd_valid), .upd_addr(ghr_q), .upd_up(upd_taken)
  );

  tp_ctr_table #(.IDX_W(GHIST_W), .CTR_W(CH_W), .RESET_VAL(CH_INIT)) u_cht (
    .clk(clk), .rst(rst),
    .rd_en(pred_req), .rd_addr(ghr_q), .rd_data(ch_s1),
    .upd_en(ch_train), .upd_addr(ghr_q), .upd_up(upd_global_pred == upd_taken)
  );

  // Stage alignment: the local counter is read one cycle after its history.
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_s1 <= 1'b0;
      valid_s2 <= 1'b0;
      gctr_s2  <= GCTR_W'(GCTR_INIT);
      ch_s2    <= CH_W'(CH_INIT);
    end else begin
      valid_s1 <= pred_req;
      valid_s2 <= valid_s1;
      if (valid_s1) begin
        gctr_s2 <= gctr_s1;
        ch_s2   <= ch_s1;
      end
    end
  end

  bp_result_t res;
  always_comb begin
    res.local_dir  = lctr_s2[LCTR_W-1];
    res.global_dir = gctr_s2[GCTR_W-1];
    res.use_global = ch_s2[CH_W-1];
    res.taken      = res.use_global ? res.global_dir : res.local_dir;
  end

  assign pred_valid      = valid_s2;
  assign pred_taken      = res.taken;
  assign pred_local      = res.local_dir;
  assign pred_global     = res.global_dir;
  assign pred_use_global = res.use_global;
endmodule

// File: rtl/tourn_bp_chk.sv
module tourn_bp_chk #(
  parameter int GHIST_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               pred_req,
  input logic               pred_valid,
  input logic               upd_valid,
  input logic               upd_taken,
  input logic [GHIST_W-1:0] ghr
);
  assert_valid_after_two_R2: assert property (@(posedge clk) disable iff (rst)
    pred_req |-> ##2 pred_valid);

  assert_valid_has_cause_R2: assert property (@(posedge clk) disable iff (rst)
    pred_valid |-> $past(pred_req, 2));

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !pred_valid);

  assert_ghr_newest_R8: assert property (@(posedge clk) disable iff (rst)
    upd_valid |=> ghr[0] == $past(upd_taken));

  assert_ghr_older_R8: assert property (@(posedge clk) disable iff (rst)
    upd_valid |=> ghr[GHIST_W-1:1] == $past(ghr[GHIST_W-2:0]));

  assert_ghr_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !upd_valid |=> $stable(ghr));
endmodule

bind tourn_bp tourn_bp_chk #(.GHIST_W(GHIST_W)) u_tourn_bp_chk (
  .clk(clk), .rst(rst), .pred_req(pred_req), .pred_valid(pred_valid),
  .upd_valid(upd_valid), .upd_taken(upd_taken), .ghr(ghr_q)
);

// File: tb/test_tourn_bp.sv
module test_tourn_bp;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pred_req = 1'b0;
  logic [31:0] pred_pc = '0;
  logic        pred_valid, pred_taken, pred_local, pred_global, pred_use_global;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_taken = 1'b0, upd_local_pred = 1'b0, upd_global_pred = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tourn_bp i_tourn_bp (
    .clk(clk), .rst(rst),
    .pred_req(pred_req), .pred_pc(pred_pc),
    .pred_valid(pred_valid), .pred_taken(pred_taken), .pred_local(pred_local),
    .pred_global(pred_global), .pred_use_global(pred_use_global),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_local_pred(upd_local_pred), .upd_global_pred(upd_global_pred)
  );

  // Reference tables built from the requirements (default parameters).
  logic [7:0] m_lht [256];
  logic [2:0] m_lct [256];
  logic [1:0] m_gct [256];
  logic [1:0] m_cht [256];
  logic [7:0] m_ghr;
  logic e_local, e_global, e_use, e_taken;
  logic o_local, o_global, o_use, o_taken;

  // Vector: [11] 1 = predict, 0 = update; [10:3] word index; [2] taken; [1] local guess; [0] global guess
  localparam logic [11:0] VEC [24] = '{
    {1'b1, 8'h10, 3'b000}, {1'b0, 8'h10, 3'b100}, {1'b0, 8'h10, 3'b100},
    {1'b1, 8'h10, 3'b000}, {1'b0, 8'h11, 3'b010}, {1'b1, 8'h11, 3'b000},
    {1'b0, 8'h10, 3'b101}, {1'b0, 8'h10, 3'b101}, {1'b1, 8'h10, 3'b000},
    {1'b0, 8'h20, 3'b110}, {1'b0, 8'h20, 3'b001}, {1'b1, 8'h20, 3'b000},
    {1'b0, 8'h11, 3'b111}, {1'b0, 8'h11, 3'b111}, {1'b0, 8'h11, 3'b000},
    {1'b1, 8'h11, 3'b000}, {1'b0, 8'h10, 3'b011}, {1'b1, 8'h10, 3'b000},
    {1'b0, 8'h20, 3'b100}, {1'b0, 8'h20, 3'b100}, {1'b0, 8'h20, 3'b100},
    {1'b1, 8'h20, 3'b000}, {1'b1, 8'h11, 3'b000}, {1'b1, 8'h10, 3'b000}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 256; i++) begin
      m_lht[i] = '0; m_lct[i] = 3'd3; m_gct[i] = 2'd1; m_cht[i] = 2'd1;
    end
    m_ghr = '0;
  endtask

  function automatic logic [2:0] sat3(input logic [2:0] v, input logic up);
    if (up)  return (v == 3'd7) ? v : v + 3'd1;
    return (v == 3'd0) ? v : v - 3'd1;
  endfunction

  function automatic logic [1:0] sat2(input logic [1:0] v, input logic up);
    if (up)  return (v == 2'd3) ? v : v + 2'd1;
    return (v == 2'd0) ? v : v - 2'd1;
  endfunction

  task automatic model_update(input logic [7:0] w, input logic t, input logic lp, input logic gp);
    logic [7:0] h;
    h = m_lht[w];
    m_lct[h] = sat3(m_lct[h], t);                       // R10: pre-shift local history
    m_lht[w] = {h[6:0], t};                             // R9
    m_gct[m_ghr] = sat2(m_gct[m_ghr], t);               // R6
    if (lp != gp) m_cht[m_ghr] = sat2(m_cht[m_ghr], gp == t);  // R7
    m_ghr = {m_ghr[6:0], t};                            // R8
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; pred_req = 1'b0; upd_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  task automatic do_upd(input logic [7:0] w, input logic t, input logic lp, input logic gp);
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = {22'd0, w, 2'b00};
    upd_taken = t; upd_local_pred = lp; upd_global_pred = gp;
    @(negedge clk);
    upd_valid = 1'b0;
    model_update(w, t, lp, gp);
  endtask

  task automatic run_pred(input logic [7:0] w);
    e_local  = m_lct[m_lht[w]][2];
    e_global = m_gct[m_ghr][1];
    e_use    = m_cht[m_ghr][1];
    e_taken  = e_use ? e_global : e_local;
    @(negedge clk);
    pred_req = 1'b1; pred_pc = {22'd0, w, 2'b00};
    @(negedge clk);
    pred_req = 1'b0;
    chk("R2 valid low one cycle after request", pred_valid, 1'b0);
    @(negedge clk);
    chk("R2 valid two cycles after request", pred_valid, 1'b1);
    o_local = pred_local; o_global = pred_global; o_use = pred_use_global; o_taken = pred_taken;
    @(negedge clk);
    chk("R2 valid single cycle", pred_valid, 1'b0);
  endtask

  task automatic cmp_model(input string tag);
    chk({tag, " R3 local"}, o_local, e_local);
    chk({tag, " R4 global"}, o_global, e_global);
    chk({tag, " R5 chooser"}, o_use, e_use);
    chk({tag, " R5 final"}, o_taken, e_taken);
  endtask

  task automatic cmp_zero(input string tag);
    chk({tag, " R1 local"}, o_local, 1'b0);
    chk({tag, " R1 global"}, o_global, 1'b0);
    chk({tag, " R1 chooser"}, o_use, 1'b0);
    chk({tag, " R1 final"}, o_taken, 1'b0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    do_reset();
    chk("R1 valid low after reset", pred_valid, 1'b0);
    run_pred(8'h05);
    cmp_zero("reset state");

    // Vector walk against the reference tables.
    for (int k = 0; k < 24; k++) begin
      if (VEC[k][11]) begin
        run_pred(VEC[k][10:3]);
        cmp_model("vector");
      end else begin
        do_upd(VEC[k][10:3], VEC[k][2], VEC[k][1], VEC[k][0]);
      end
    end

    // R7/R6: pin the shared history at zero, swing one chooser entry to global.
    do_reset();
    for (int k = 0; k < 3; k++) do_upd(8'h20, 1'b0, 1'b1, 1'b0);
    run_pred(8'h20);
    chk("R7 chooser moved toward global", o_use, 1'b1);
    chk("R6 global counter at floor", o_global, 1'b0);
    chk("R6 local counter down", o_local, 1'b0);
    // Further disagreements saturate; an agreeing update leaves the chooser alone.
    for (int k = 0; k < 3; k++) do_upd(8'h20, 1'b0, 1'b1, 1'b0);
    do_upd(8'h20, 1'b0, 1'b0, 1'b0);
    run_pred(8'h20);
    chk("R7 agreeing update ignored by chooser", o_use, 1'b1);
    cmp_model("saturated chooser");
    // Local correct now: chooser steps back toward local (3 -> 2 keeps global, 2 -> 1 local).
    do_upd(8'h20, 1'b0, 1'b0, 1'b1);
    run_pred(8'h20);
    chk("R7 one step back still global", o_use, 1'b1);
    do_upd(8'h20, 1'b0, 1'b0, 1'b1);
    run_pred(8'h20);
    chk("R7 two steps back selects local", o_use, 1'b0);

    // R9/R10/R6: train one branch taken nine times; another branch unaffected.
    do_reset();
    for (int k = 0; k < 9; k++) do_upd(8'h33, 1'b1, 1'b0, 1'b0);
    run_pred(8'h33);
    chk("R10 counter at all-ones history trained", o_local, 1'b1);
    cmp_model("taken run");
    run_pred(8'h34);
    cmp_model("R9 other branch history untouched");
    // R8: shared history all ones now selects a global counter that saw one taken.
    chk("R8 history shift selects trained counter", o_global, 1'b1);
    for (int k = 0; k < 12; k++) do_upd(8'h33, 1'b1, 1'b1, 1'b1);
    run_pred(8'h33);
    cmp_model("R6 upper saturation");
    do_upd(8'h33, 1'b0, 1'b1, 1'b1);
    run_pred(8'h33);
    cmp_model("R8 not-taken shift");

    // R1: reset in mid-run restores the initial state.
    do_reset();
    run_pred(8'h33);
    cmp_zero("mid-run reset");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule